// File: doc/BRIEF.md
# Loopback Round-Trip Latency Timer

This block sits between a receive word stream (fed from an inbound data FIFO) and a transmit word stream (feeding an outbound DMA FIFO). Every valid word that arrives is sent straight back out one clock later. When nothing is being measured, the far end keeps the loop busy with a constant filler word. The filler word is a 32-bit pattern repeated across every lane of the wide data word.

To take a measurement, the host programs a filler pattern and a distinct probe pattern, then pulses an arm input. On that edge the block clears a timestamp counter and starts it. While the measurement runs, each filler word that passes through the block is replaced on its way out by the probe word. The counter stops on the first clock edge at which a valid received word equals the probe word in every lane. The stopped count is then the round-trip time in clock periods: 4 ns per count at 250 MHz.

The counter saturates instead of wrapping. A saturated count is reported as a timeout. A controller with four states sequences the work: ST_IDLE (after reset), ST_RUN (counting and substituting), ST_DONE (probe returned) and ST_TOUT (counter saturated).

The transitions are:
- ARM: from any state to ST_RUN, when arm is high.
- HIT: ST_RUN to ST_DONE, when a valid received word matches the probe word.
- SATURATE: ST_RUN to ST_TOUT, when the counter would reach its top value with no hit.

Top module: `lat_loop_timer`

## Requirements
- R1: While and after reset: tx_valid_o is 0, lat_count_o is 0, and lat_busy_o, lat_done_o and lat_timeout_o are all 0.
- R2: A valid received word appears on tx_data_o, with tx_valid_o high, on the clock edge after it is sampled. The word is unchanged whenever the block is not in ST_RUN, including when it equals the filler word.
- R3: An arm pulse, in any state, gives lat_count_o = 0, lat_busy_o = 1, lat_done_o = 0 and lat_timeout_o = 0 after the same edge. An arm pulse during ST_RUN restarts the count.
- R4: In ST_RUN, a valid received word in which all DATA_W/PAT_W lanes of PAT_W bits equal fill_pat_i leaves as the probe word, with test_pat_i in every lane. A word that matches the filler in only some lanes, and any non-filler word, leaves unchanged.
- R5: In ST_RUN, the first edge that samples rx_valid_i = 1 with every lane equal to test_pat_i moves the block to ST_DONE. lat_count_o then equals the number of edges from the arm edge to that edge, lat_done_o = 1 and lat_busy_o = 0. Both hold until the next arm.
- R6: In ST_RUN, without arm, lat_count_o rises by exactly one per clock edge.
- R7: If no hit occurs, lat_count_o stops at 2^CNT_W-1, lat_timeout_o rises and lat_busy_o falls on that same edge. Later probe words do not change these outputs until the next arm.
- R8: A word sampled with rx_valid_i = 0 produces tx_valid_o = 0. It is neither substituted nor able to stop the count.
- R9: A received word that equals the probe word in all lanes but one does not stop the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one count |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Host pulse that clears the counter and starts a measurement |
| fill_pat_i | input | PAT_W (32) | Filler pattern, repeated in each lane |
| test_pat_i | input | PAT_W (32) | Probe pattern, repeated in each lane |
| rx_valid_i | input | 1 | Received word is valid |
| rx_data_i | input | DATA_W (256) | Received word from the inbound FIFO |
| tx_valid_o | output | 1 | Transmit word is valid |
| tx_data_o | output | DATA_W (256) | Transmit word toward the outbound FIFO |
| lat_count_o | output | CNT_W (32) | Timestamp counter value |
| lat_busy_o | output | 1 | Measurement running (ST_RUN) |
| lat_done_o | output | 1 | Count is a valid round-trip time (ST_DONE) |
| lat_timeout_o | output | 1 | Counter saturated with no probe returned (ST_TOUT) |

## Verification
The assertions assume the following about the inputs:
- The filler and probe patterns are held steady while a measurement runs and differ from each other.
- arm_i is a single-cycle pulse.
- rx_valid_i is always a known value.

The stimulus keeps within these assumptions. Patterns are fixed constants, every arm is raised for exactly one cycle, and rx_valid_i is driven at every instant. The round trip is closed in the bench through a delay line of selectable length, which is swept from zero to 31 stages, so the expected count is the line length plus two. A narrow 12-bit counter lets saturation be reached in a few thousand cycles.

// File: rtl/lat_pkg.sv
package lat_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2,
        ST_TOUT = 2'd3
    } lat_state_e;
endpackage

// File: rtl/lat_word_match.sv
// Full-word compare of a data word against a lane pattern repeated in every lane.
module lat_word_match #(
    parameter int DATA_W = 256,
    parameter int PAT_W  = 32
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [PAT_W-1:0]  pat_i,
    output logic              match_o
);
    localparam int LANES = DATA_W / PAT_W;

    logic [LANES-1:0] lane_eq;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (word_i[g*PAT_W +: PAT_W] == pat_i);
    end

    assign match_o = &lane_eq;
endmodule

// File: rtl/lat_out_stage.sv
// Transmit register: forwards received words, swapping in the probe word on request.
module lat_out_stage #(
    parameter int DATA_W = 256,
    parameter int PAT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              swap_i,
    input  logic [PAT_W-1:0]  probe_pat_i,
    output logic              tx_valid_o,
    output logic [DATA_W-1:0] tx_data_o
);
    localparam int LANES = DATA_W / PAT_W;

    logic [DATA_W-1:0] probe_word;

    for (genvar g = 0; g < LANES; g++) begin : g_rep
        assign probe_word[g*PAT_W +: PAT_W] = probe_pat_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid_o <= 1'b0;
            tx_data_o  <= '0;
        end else begin
            tx_valid_o <= rx_valid_i;
            if (rx_valid_i) begin
                tx_data_o <= swap_i ? probe_word : rx_data_i;
            end
        end
    end
endmodule

// File: rtl/lat_sat_counter.sv
// Saturating up-counter with synchronous clear and a one-below-top flag.
module lat_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             pre_top_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] CNT_PRE = {{(CNT_W-1){1'b1}}, 1'b0};

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            count_o <= '0;
        end else if (en_i && (count_o != CNT_TOP)) begin
            count_o <= count_o + 1'b1;
        end
    end

    assign pre_top_o = (count_o == CNT_PRE);
endmodule

// File: rtl/lat_loop_timer.sv
// Loopback path with a content-triggered round-trip timer.
module lat_loop_timer
    import lat_pkg::*;
#(
    parameter int DATA_W = 256,
    parameter int PAT_W  = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [PAT_W-1:0]  fill_pat_i,
    input  logic [PAT_W-1:0]  test_pat_i,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic              tx_valid_o,
    output logic [DATA_W-1:0] tx_data_o,
    output logic [CNT_W-1:0]  lat_count_o,
    output logic              lat_busy_o,
    output logic              lat_done_o,
    output logic              lat_timeout_o
);
    lat_state_e state_q, state_d;

    logic is_fill, is_probe, hit, pre_top;
    logic cnt_clr, cnt_en, swap;

    lat_word_match #(.DATA_W(DATA_W), .PAT_W(PAT_W)) u_fill_cmp (
        .word_i (rx_data_i),
        .pat_i  (fill_pat_i),
        .match_o(is_fill)
    );

    lat_word_match #(.DATA_W(DATA_W), .PAT_W(PAT_W)) u_probe_cmp (
        .word_i (rx_data_i),
        .pat_i  (test_pat_i),
        .match_o(is_probe)
    );

    assign hit = rx_valid_i && is_probe;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: ARM, HIT, SATURATE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_TOUT: begin
                if (arm_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (arm_i)        state_d = ST_RUN;
                else if (hit)     state_d = ST_DONE;
                else if (pre_top) state_d = ST_TOUT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        lat_busy_o    = (state_q == ST_RUN);
        lat_done_o    = (state_q == ST_DONE);
        lat_timeout_o = (state_q == ST_TOUT);
        cnt_clr       = arm_i;
        cnt_en        = (state_q == ST_RUN) && !arm_i;
        swap          = (state_q == ST_RUN) && is_fill;
    end

    lat_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cnt_clr),
        .en_i     (cnt_en),
        .count_o  (lat_count_o),
        .pre_top_o(pre_top)
    );

    lat_out_stage #(.DATA_W(DATA_W), .PAT_W(PAT_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid_i (rx_valid_i),
        .rx_data_i  (rx_data_i),
        .swap_i     (swap),
        .probe_pat_i(test_pat_i),
        .tx_valid_o (tx_valid_o),
        .tx_data_o  (tx_data_o)
    );
endmodule

// File: rtl/lat_loop_timer_chk.sv
module lat_loop_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm_i,
    input logic             rx_valid_i,
    input logic             tx_valid_o,
    input logic             busy,
    input logic             done,
    input logic             timeout,
    input logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R3
    arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (busy && !done && !timeout && count == '0));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !arm_i && !(&count)) |=> (count == $past(count) + ONE));

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm_i) |=> (done && $stable(count)));

    // R5
    done_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rx_valid_i));

    // R7
    tout_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (&count));

    // R7
    tout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !arm_i) |=> timeout);

    // R2
    tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_i |=> tx_valid_o);

    // R8
    tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_i |=> !tx_valid_o);
endmodule

bind lat_loop_timer lat_loop_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm_i),
    .rx_valid_i(rx_valid_i),
    .tx_valid_o(tx_valid_o),
    .busy      (lat_busy_o),
    .done      (lat_done_o),
    .timeout   (lat_timeout_o),
    .count     (lat_count_o)
);

// File: tb/lat_loop_timer_tb_top.sv
module lat_loop_timer_tb_top;
    localparam int DW = 64;
    localparam int PW = 16;
    localparam int CW = 12;
    localparam int LN = DW / PW;
    localparam logic [PW-1:0] FILL = 16'hA5A5;
    localparam logic [PW-1:0] TEST = 16'h3C0F;
    localparam logic [DW-1:0] FILLW = {LN{FILL}};
    localparam logic [DW-1:0] TESTW = {LN{TEST}};
    localparam int TOP = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic          rx_valid = 1'b1;
    logic [DW-1:0] rx_data;
    logic          tx_valid;
    logic [DW-1:0] tx_data;
    logic [CW-1:0] cnt;
    logic          busy, done, tout;

    int            src = 1;      // 0 loop, 1 filler, 2 custom
    int            dly = 0;
    logic [DW-1:0] cust = '0;
    logic [DW-1:0] line_in;
    logic [DW-1:0] line [0:63];

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        if (src == 0)      line_in = tx_valid ? tx_data : FILLW;
        else if (src == 1) line_in = FILLW;
        else               line_in = cust;
        rx_data = (dly == 0) ? line_in : line[dly-1];
    end

    always @(posedge clk) begin
        line[0] <= line_in;
        for (int i = 1; i < 64; i++) line[i] <= line[i-1];
    end

    lat_loop_timer #(.DATA_W(DW), .PAT_W(PW), .CNT_W(CW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_i        (arm),
        .fill_pat_i   (FILL),
        .test_pat_i   (TEST),
        .rx_valid_i   (rx_valid),
        .rx_data_i    (rx_data),
        .tx_valid_o   (tx_valid),
        .tx_data_o    (tx_data),
        .lat_count_o  (cnt),
        .lat_busy_o   (busy),
        .lat_done_o   (done),
        .lat_timeout_o(tout)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm_pulse();
        arm = 1'b1;
        tick(1);
        arm = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        finished = 1'b1;
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [DW-1:0] w;
        int waited;
        tick(3);
        // R1 reset state
        check(tx_valid == 1'b0, "R1", "tx_valid", 64'(tx_valid), 0);
        check(cnt == '0, "R1", "count", 64'(cnt), 0);
        check({busy, done, tout} == 3'b000, "R1", "flags", 64'({busy, done, tout}), 0);
        rst_n = 1'b1;
        tick(1);
        check({busy, done, tout} == 3'b000, "R1", "flags after release", 64'({busy, done, tout}), 0);

        // R2 pass-through in ST_IDLE, filler included
        dly = 0;
        src = 2;
        for (int k = 0; k < 8; k++) begin
            cust = (k == 7) ? FILLW : (64'h0123_4567_89AB_CDEF * (k + 1)) ^ {8{8'(k)}};
            tick(1);
            check(tx_valid && tx_data == cust, "R2", "idle forward", tx_data, cust);
        end

        // R8 invalid word gives no output
        rx_valid = 1'b0;
        tick(1);
        check(tx_valid == 1'b0, "R8", "tx_valid on invalid", 64'(tx_valid), 0);
        rx_valid = 1'b1;

        // R5 round trip sweep over loop delays: expected count = delay + 2
        for (int d = 0; d < 32; d++) begin
            dly = d;
            src = 1;
            tick(d + 4);
            src = 0;
            arm_pulse();
            check(busy && cnt == '0, "R3", "armed and cleared", 64'(cnt), 0);
            waited = 0;
            while (!done && waited < 200) begin
                tick(1);
                waited++;
            end
            check(done == 1'b1, "R5", "stopped", 64'(done), 1);
            check(int'(cnt) == d + 2, "R5", "round trip count", 64'(cnt), 64'(d + 2));
            tick(3);
            check(done && int'(cnt) == d + 2, "R5", "count held", 64'(cnt), 64'(d + 2));
        end

        // R6 counting, R3 re-arm while running
        dly = 0;
        src = 1;
        tick(2);
        arm_pulse();
        tick(5);
        check(busy && cnt == 12'd5, "R6", "count after five edges", 64'(cnt), 5);
        arm_pulse();
        check(busy && cnt == '0 && !done, "R3", "restart mid run", 64'(cnt), 0);

        // R4 substitution and lane-exact filler compare (in ST_RUN)
        src = 2;
        cust = FILLW;
        tick(1);
        check(tx_data == TESTW, "R4", "filler swapped for probe", tx_data, TESTW);
        for (int i = 0; i < LN; i++) begin
            w = FILLW ^ (64'h0001 << (i * PW));
            cust = w;
            tick(1);
            check(tx_data == w, "R4", "partial filler unchanged", tx_data, w);
        end
        // R9 probe with one lane off does not stop
        for (int i = 0; i < LN; i++) begin
            cust = TESTW ^ (64'h0080 << (i * PW));
            tick(1);
            check(busy && !done, "R9", "near-probe ignored", 64'({busy, done}), 64'(2));
        end
        // R8 invalid probe does not stop
        rx_valid = 1'b0;
        cust = TESTW;
        tick(1);
        check(busy && !done && !tx_valid, "R8", "invalid probe ignored", 64'({busy, done, tx_valid}), 64'(4));
        rx_valid = 1'b1;
        tick(1);
        check(done && cnt == 12'd11, "R5", "stop on valid probe", 64'(cnt), 11);
        check(tx_data == TESTW, "R4", "probe forwarded unchanged", tx_data, TESTW);

        // R2 in ST_DONE filler is not swapped
        cust = FILLW;
        tick(1);
        check(tx_data == FILLW, "R2", "done forward filler", tx_data, FILLW);

        // R7 saturation
        src = 1;
        arm_pulse();
        tick(TOP - 1);
        check(busy && int'(cnt) == TOP - 1, "R7", "one below top", 64'(cnt), 64'(TOP - 1));
        tick(1);
        check(tout && !busy && int'(cnt) == TOP, "R7", "saturated", 64'(cnt), 64'(TOP));
        tick(10);
        check(tout && int'(cnt) == TOP, "R7", "saturation held", 64'(cnt), 64'(TOP));
        src = 2;
        cust = TESTW;
        tick(1);
        check(tout && !done, "R7", "late probe ignored", 64'({done, tout}), 1);
        arm_pulse();
        check(busy && !tout && cnt == '0, "R3", "re-arm after timeout", 64'(cnt), 0);

        finish_run();
    end
endmodule